// File: doc/BRIEF.md
# Indexed Block-Transfer SMBus Control Register Target

This block is the control-register front end of a clock generator. It is an SMBus target that holds a small bank of 8-bit registers and shows their contents on a flat parallel bus to the clock logic around it. The bus lines arrive as open-drain inputs. The block pulls SDA low through a separate output, and a strap input selects one of two 7-bit target addresses.

Every transfer is indexed and carries a byte count. A host write sends a starting index, then a count, then that many data bytes, which go to consecutive registers. A host read sends the index in a write phase and then issues a repeated start. The target answers with the contents of the count register, followed by register bytes streamed from the index for as long as the host acknowledges. One register is read-only and carries a fixed identification value. Indices past the last implemented register take no writes and read back as zero.

Top module: `idx_smbus_regs`

## Requirements
- R1: With the strap input at 0 the target answers 7-bit address 68h (address bytes D0h write, D1h read). With the strap at 1 it answers 60h (C0h/C1h). A matching address byte is acknowledged.
- R2: An address byte that does not match is not acknowledged. The target then leaves SDA released until the next start condition.
- R3: A write (start, address+W, index N, count X, X data bytes, stop) stores the data bytes in registers N, N+1, … N+X-1 and acknowledges every byte.
- R4: Data bytes sent beyond the count X are not acknowledged and change no register.
- R5: A read (start, address+W, index N, repeated start, address+R) returns the value of register 8 first, then registers N, N+1, … in order, for as long as the host acknowledges each byte.
- R6: Register 8 resets to 09h and is writable. Its current value is the first byte returned by every read.
- R7: Register 6 is read-only and holds {revision nibble, 1h}, which is 01h with the default revision 0. Writes to it are dropped, but the index still advances past it.
- R8: Reset values are: reg0=02h, reg1=FFh, reg2=3Fh, reg3=00h, reg4=00h, reg5=3Ch, reg7=22h, reg8=09h, and all other registers 00h.
- R9: Indices at or above 22 (past register 21) store nothing and read back 00h.
- R10: When the host does not acknowledge a byte the target is sending, the target stops sending and keeps SDA released until the next start.
- R11: A start or stop condition seen in the middle of a transfer abandons it. A start begins a new address phase.
- R12: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least ten times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| addr_sel_i | input | 1 | Address strap: 0 selects 68h, 1 selects 60h |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | NREG*8 | Register contents, register i in bits [8i+7:8i] |

## Verification
The bench checks bytes written past the count. A design that ignores the count would acknowledge and store them. It writes the read-only register next to a writable one, which catches a design that either stores the byte or stops advancing the index. Reads that cross the end of the bank must return zero bytes, which exposes an index that wraps back into the bank or an unmasked read mux. It also sends a mismatched address, a host NACK in the middle of a read, and a repeated start inside a write. A target that keeps driving after these events would corrupt the bus, and one that keeps its state would store data to the wrong register.

// File: rtl/idxsmb_pkg.sv
package idxsmb_pkg;

   // transfer phases of the target
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_INDEX,
      PH_COUNT,
      PH_WDATA,
      PH_TX,
      PH_MUTE
   } phase_t;

   localparam int unsigned RO_REG  = 6;   // identification byte
   localparam int unsigned CNT_REG = 8;   // read byte count

   // power-on contents of register i
   function automatic logic [7:0] dflt_byte(input int unsigned i, input logic [3:0] rev);
      logic [7:0] v;
      case (i)
         0:       v = 8'h02;
         1:       v = 8'hFF;
         2:       v = 8'h3F;
         5:       v = 8'h3C;
         6:       v = {rev, 4'h1};
         7:       v = 8'h22;
         8:       v = 8'h09;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/idxsmb_lfilt.sv
// Line conditioner: synchronizer chain followed by an agreement filter.
module idxsmb_lfilt #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 3
)(
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("idxsmb_lfilt: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   level_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end

   assign synced = sync_q[SYNC_STAGES-1];

   if (FILT_LEN <= 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) level_q <= 1'b1;
         else        level_q <= synced;
      end
   end else begin : g_vote
      logic [FILT_LEN-1:0] hist_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist_q  <= '1;
            level_q <= 1'b1;
         end else begin
            hist_q <= {hist_q[FILT_LEN-2:0], synced};
            if (&hist_q)       level_q <= 1'b1;
            else if (~|hist_q) level_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= level_q;
   end

   assign level_o = level_q;
   assign rise_o  = level_q & ~prev_q;
   assign fall_o  = ~level_q & prev_q;

endmodule

// File: rtl/idxsmb_bank.sv
// Register storage with one read-only identification byte.
module idxsmb_bank
   import idxsmb_pkg::*;
#(
   parameter int unsigned NREG   = 22,
   parameter int unsigned IDX_W  = 8,
   parameter logic [3:0]  REV_ID = 4'h0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [7:0]        wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [7:0]        rd_data,
   output logic [7:0]        cnt_o,
   output logic [NREG*8-1:0] regs_o
);

   if (NREG <= CNT_REG) begin : g_bad_nreg
      $error("idxsmb_bank: NREG must cover the count register");
   end
   if (NREG > (1 << IDX_W)) begin : g_bad_idx
      $error("idxsmb_bank: IDX_W too narrow for NREG");
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == RO_REG) begin : g_ro
         assign regs_o[g*8 +: 8] = dflt_byte(g, REV_ID);
      end else begin : g_rw
         logic [7:0] val_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               val_q <= dflt_byte(g, REV_ID);
            else if (wr_en && (wr_idx == IDX_W'(g)))
               val_q <= wr_data;
         end
         assign regs_o[g*8 +: 8] = val_q;
      end
   end

   // out-of-range indices read as zero
   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NREG; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = regs_o[i*8 +: 8];
      end
   end

   assign cnt_o = regs_o[CNT_REG*8 +: 8];

endmodule

// File: rtl/idxsmb_link.sv
// Bus protocol engine: conditions, address match, index, count, data.
module idxsmb_link
   import idxsmb_pkg::*;
#(
   parameter int unsigned IDX_W       = 8,
   parameter logic [6:0]  ADDR_STRAP0 = 7'h68,
   parameter logic [6:0]  ADDR_STRAP1 = 7'h60
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_lvl,
   input  logic             sda_lvl,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_rise,
   input  logic             sda_fall,
   input  logic             addr_sel,
   input  logic [7:0]       cnt_val,
   input  logic [7:0]       rd_data,
   output logic             sda_pull,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             start_ev,
   output logic             stop_ev
);

   phase_t           ph_q, nxt_q, nxt_ph;
   logic [3:0]       bitcnt_q;
   logic [7:0]       sreg_q;
   logic             in_ack_q;
   logic             pull_q;
   logic [IDX_W-1:0] idx_q;
   logic [7:0]       left_q;
   logic             host_ack_q;
   logic [6:0]       my_addr;
   logic             rx_phase;
   logic             rx_done;
   logic             give_ack;

   assign start_ev = scl_lvl & sda_fall;
   assign stop_ev  = scl_lvl & sda_rise;
   assign my_addr  = addr_sel ? ADDR_STRAP1 : ADDR_STRAP0;

   assign rx_phase = (ph_q == PH_ADDR) || (ph_q == PH_INDEX) ||
                     (ph_q == PH_COUNT) || (ph_q == PH_WDATA);
   assign rx_done  = rx_phase && scl_fall && (bitcnt_q == 4'd8) && !in_ack_q &&
                     !start_ev && !stop_ev;

   // decision taken when a received byte completes
   always_comb begin
      give_ack = 1'b0;
      nxt_ph   = PH_MUTE;
      wr_en    = 1'b0;
      case (ph_q)
         PH_ADDR: begin
            if (sreg_q[7:1] == my_addr) begin
               give_ack = 1'b1;
               nxt_ph   = sreg_q[0] ? PH_TX : PH_INDEX;
            end
         end
         PH_INDEX: begin
            give_ack = 1'b1;
            nxt_ph   = PH_COUNT;
         end
         PH_COUNT: begin
            give_ack = 1'b1;
            nxt_ph   = PH_WDATA;
         end
         PH_WDATA: begin
            if (left_q != 8'd0) begin
               give_ack = 1'b1;
               nxt_ph   = PH_WDATA;
               wr_en    = rx_done;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q       <= PH_IDLE;
         nxt_q      <= PH_IDLE;
         bitcnt_q   <= 4'd0;
         sreg_q     <= 8'h00;
         in_ack_q   <= 1'b0;
         pull_q     <= 1'b0;
         idx_q      <= '0;
         left_q     <= 8'd0;
         host_ack_q <= 1'b0;
      end else if (stop_ev) begin
         ph_q     <= PH_IDLE;
         pull_q   <= 1'b0;
         in_ack_q <= 1'b0;
      end else if (start_ev) begin
         ph_q     <= PH_ADDR;
         bitcnt_q <= 4'd0;
         pull_q   <= 1'b0;
         in_ack_q <= 1'b0;
      end else if (ph_q == PH_TX) begin
         if (scl_rise && bitcnt_q == 4'd8) host_ack_q <= ~sda_lvl;
         if (scl_fall) begin
            if (bitcnt_q < 4'd7) begin
               bitcnt_q <= bitcnt_q + 4'd1;
               pull_q   <= ~sreg_q[6];
               sreg_q   <= {sreg_q[6:0], 1'b0};
            end else if (bitcnt_q == 4'd7) begin
               bitcnt_q <= 4'd8;
               pull_q   <= 1'b0;
            end else if (host_ack_q) begin
               sreg_q   <= rd_data;
               pull_q   <= ~rd_data[7];
               idx_q    <= idx_q + IDX_W'(1);
               bitcnt_q <= 4'd0;
            end else begin
               ph_q <= PH_MUTE;
            end
         end
      end else if (rx_phase) begin
         if (scl_rise && bitcnt_q < 4'd8 && !in_ack_q) begin
            sreg_q   <= {sreg_q[6:0], sda_lvl};
            bitcnt_q <= bitcnt_q + 4'd1;
         end
         if (rx_done) begin
            in_ack_q <= 1'b1;
            pull_q   <= give_ack;
            nxt_q    <= nxt_ph;
            case (ph_q)
               PH_INDEX: idx_q  <= IDX_W'(sreg_q);
               PH_COUNT: left_q <= sreg_q;
               PH_WDATA: begin
                  if (give_ack) begin
                     idx_q  <= idx_q + IDX_W'(1);
                     left_q <= left_q - 8'd1;
                  end
               end
               default: ;
            endcase
         end else if (scl_fall && in_ack_q) begin
            in_ack_q <= 1'b0;
            bitcnt_q <= 4'd0;
            ph_q     <= nxt_q;
            if (nxt_q == PH_TX) begin
               sreg_q <= cnt_val;
               pull_q <= ~cnt_val[7];
            end else begin
               pull_q <= 1'b0;
            end
         end
      end
   end

   assign sda_pull = pull_q;
   assign wr_idx   = idx_q;
   assign wr_data  = sreg_q;
   assign rd_idx   = idx_q;

endmodule

// File: rtl/idx_smbus_regs.sv
module idx_smbus_regs
   import idxsmb_pkg::*;
#(
   parameter int unsigned NREG        = 22,
   parameter int unsigned IDX_W       = 8,
   parameter logic [6:0]  ADDR_STRAP0 = 7'h68,
   parameter logic [6:0]  ADDR_STRAP1 = 7'h60,
   parameter logic [3:0]  REV_ID      = 4'h0,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              addr_sel_i,
   output logic              sda_pull_o,
   output logic [NREG*8-1:0] regs_o
);

   localparam int unsigned NLINES = 2;   // bit 1 = SCL, bit 0 = SDA

   if (ADDR_STRAP0 == ADDR_STRAP1) begin : g_bad_addr
      $error("idx_smbus_regs: strap addresses must differ");
   end

   logic [NLINES-1:0] raw, lvl, rise, fall;
   logic              scl_lvl;
   logic              start_ev, stop_ev;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [7:0]        wr_data, rd_data, cnt_val;

   assign raw = {scl_i, sda_i};

   for (genvar l = 0; l < NLINES; l++) begin : g_line
      idxsmb_lfilt #(
         .SYNC_STAGES (SYNC_STAGES),
         .FILT_LEN    (FILT_LEN)
      ) u_filt (
         .clk     (clk),
         .rst_n   (rst_n),
         .raw_i   (raw[l]),
         .level_o (lvl[l]),
         .rise_o  (rise[l]),
         .fall_o  (fall[l])
      );
   end

   assign scl_lvl = lvl[1];

   idxsmb_link #(
      .IDX_W       (IDX_W),
      .ADDR_STRAP0 (ADDR_STRAP0),
      .ADDR_STRAP1 (ADDR_STRAP1)
   ) u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_lvl  (scl_lvl),
      .sda_lvl  (lvl[0]),
      .scl_rise (rise[1]),
      .scl_fall (fall[1]),
      .sda_rise (rise[0]),
      .sda_fall (fall[0]),
      .addr_sel (addr_sel_i),
      .cnt_val  (cnt_val),
      .rd_data  (rd_data),
      .sda_pull (sda_pull_o),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .rd_idx   (rd_idx),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   idxsmb_bank #(
      .NREG   (NREG),
      .IDX_W  (IDX_W),
      .REV_ID (REV_ID)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .cnt_o   (cnt_val),
      .regs_o  (regs_o)
   );

endmodule

// File: rtl/idx_smbus_regs_chk.sv
module idx_smbus_regs_chk
   import idxsmb_pkg::*;
#(
   parameter int unsigned NREG  = 22,
   parameter int unsigned IDX_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              scl_lvl,
   input logic              sda_pull,
   input logic              start_ev,
   input logic              stop_ev,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [NREG*8-1:0] regs
);

   // R12
   sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull != $past(sda_pull)) |-> !scl_lvl);

   // R11
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> !sda_pull);

   // R11
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !sda_pull);

   // R3
   write_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (regs != $past(regs)) |-> $past(wr_en));

   // R9
   oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx >= IDX_W'(NREG))) |=> $stable(regs));

   // R7
   ro_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx == IDX_W'(RO_REG))) |=> $stable(regs[RO_REG*8 +: 8]));

endmodule

bind idx_smbus_regs idx_smbus_regs_chk #(
   .NREG  (NREG),
   .IDX_W (IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_lvl  (scl_lvl),
   .sda_pull (sda_pull_o),
   .start_ev (start_ev),
   .stop_ev  (stop_ev),
   .wr_en    (wr_en),
   .wr_idx   (wr_idx),
   .regs     (regs_o)
);

// File: tb/idx_smbus_regs_tb.sv
module idx_smbus_regs_tb;

   localparam int CLK_P  = 10;
   localparam int QCYC   = 10;       // clock cycles per quarter bus bit
   localparam int NREG   = 22;
   localparam int WD_CYC = 190000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_h = 1'b1;
   logic sda_h = 1'b1;
   logic strap = 1'b0;
   logic sda_pull;
   logic sda_bus;
   logic [NREG*8-1:0] regs;

   assign sda_bus = sda_h & ~sda_pull;

   always #(CLK_P/2) clk = ~clk;

   idx_smbus_regs #(.NREG(NREG)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_h),
      .sda_i      (sda_bus),
      .addr_sel_i (strap),
      .sda_pull_o (sda_pull),
      .regs_o     (regs)
   );

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   int r12_viol = 0;
   logic [7:0] exp_r [NREG];
   logic [7:0] wbuf [16];
   logic [7:0] rbuf [16];
   logic prev_pull = 1'b0;

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_CYC) begin
         n_run++; n_fail++;
         $display("FAIL all: watchdog expired, actual %0d cycles expected < %0d", cyc, WD_CYC);
         summary();
         $finish;
      end
   end

   // R12 monitor: drive changes only while SCL is low
   always @(negedge clk) begin
      if (rst_n && scl_h && (sda_pull != prev_pull)) r12_viol++;
      prev_pull <= sda_pull;
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
      n_run++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic chk_regs(input string req);
      int bad = -1;
      for (int i = 0; i < NREG; i++)
         if (bad < 0 && regs[i*8 +: 8] !== exp_r[i]) bad = i;
      n_run++;
      if (bad >= 0) begin
         n_fail++;
         $display("FAIL %s register %0d: actual %0h expected %0h", req, bad, regs[bad*8 +: 8], exp_r[bad]);
      end
   endtask

   task automatic qwait();
      repeat (QCYC) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_h = 1'b1; qwait();
      scl_h = 1'b1; qwait();
      sda_h = 1'b0; qwait();
      scl_h = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; qwait();
      scl_h = 1'b1; qwait();
      sda_h = 1'b1; qwait();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         sda_h = b[i]; qwait();
         scl_h = 1'b1; qwait(); qwait();
         scl_h = 1'b0; qwait();
      end
      sda_h = 1'b1; qwait();
      scl_h = 1'b1; qwait();
      acked = ~sda_bus;
      qwait();
      scl_h = 1'b0; qwait();
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      sda_h = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         qwait();
         scl_h = 1'b1; qwait();
         b[i] = sda_bus;
         qwait();
         scl_h = 1'b0;
      end
      qwait();
      sda_h = ~give_ack; qwait();
      scl_h = 1'b1; qwait(); qwait();
      scl_h = 1'b0; qwait();
      sda_h = 1'b1;
   endtask

   // update expected contents following R3, R4, R7, R9
   task automatic model_wr(input int n, input int x, input int nsent);
      for (int k = 0; k < nsent; k++) begin
         int idx = (n + k) % 256;
         if (k < x && idx < NREG && idx != 6) exp_r[idx] = wbuf[k];
      end
   endtask

   task automatic do_write(input logic [6:0] a, input int n, input int x, input int nsent,
                           output logic [31:0] ackv);
      logic ak;
      ackv = '0;
      bus_start();
      send_byte({a, 1'b0}, ak); ackv[0] = ak;
      send_byte(8'(n), ak);     ackv[1] = ak;
      send_byte(8'(x), ak);     ackv[2] = ak;
      for (int k = 0; k < nsent; k++) begin
         send_byte(wbuf[k], ak); ackv[3+k] = ak;
      end
      bus_stop();
   endtask

   task automatic do_read(input logic [6:0] a, input int n, input int nd, output logic [7:0] cnt);
      logic ak;
      bus_start();
      send_byte({a, 1'b0}, ak);
      send_byte(8'(n), ak);
      bus_start();
      send_byte({a, 1'b1}, ak);
      recv_byte(nd > 0, cnt);
      for (int k = 0; k < nd; k++) recv_byte(k < nd - 1, rbuf[k]);
      bus_stop();
   endtask

   task automatic t_reset();
      chk_regs("R8");
      chk("R7", "id byte at reset", regs[6*8 +: 8], 8'h01);
      chk("R6", "count byte at reset", regs[8*8 +: 8], 8'h09);
      chk("R2", "SDA released at reset", sda_pull, 1'b0);
   endtask

   task automatic t_address();
      logic [31:0] av;
      strap = 1'b0;
      wbuf[0] = 8'hAA;
      do_write(7'h60, 0, 1, 1, av);
      chk("R2", "acks for foreign address", av[3:0], 4'h0);
      chk_regs("R2");
      wbuf[0] = 8'h5C;
      do_write(7'h68, 10, 1, 1, av);
      model_wr(10, 1, 1);
      chk("R1", "acks strap0 address 68h", av[3:0], 4'hF);
      strap = 1'b1; qwait();
      wbuf[0] = 8'h6D;
      do_write(7'h60, 11, 1, 1, av);
      model_wr(11, 1, 1);
      chk("R1", "acks strap1 address 60h", av[3:0], 4'hF);
      wbuf[0] = 8'h99;
      do_write(7'h68, 12, 1, 1, av);
      chk("R2", "acks for 68h with strap1", av[3:0], 4'h0);
      strap = 1'b0; qwait();
      chk_regs("R1");
   endtask

   task automatic t_block_write();
      logic [31:0] av;
      wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
      do_write(7'h68, 1, 3, 3, av);
      model_wr(1, 3, 3);
      chk("R3", "acks of block write", av[5:0], 6'h3F);
      chk_regs("R3");
   endtask

   task automatic t_overcount();
      logic [31:0] av;
      wbuf[0] = 8'h11; wbuf[1] = 8'hEE;
      do_write(7'h68, 3, 1, 2, av);
      model_wr(3, 1, 2);
      chk("R4", "ack of byte past count", av[4:0], 5'h0F);
      chk_regs("R4");
   endtask

   task automatic t_read();
      logic [31:0] av;
      logic [7:0] c;
      wbuf[0] = 8'h04;
      do_write(7'h68, 8, 1, 1, av);
      model_wr(8, 1, 1);
      do_read(7'h68, 0, 4, c);
      chk("R6", "count byte after rewrite", c, 8'h04);
      for (int k = 0; k < 4; k++) chk("R5", "streamed byte", rbuf[k], exp_r[k]);
   endtask

   task automatic t_readonly();
      logic [31:0] av;
      logic [7:0] c;
      wbuf[0] = 8'hFF; wbuf[1] = 8'h77;
      do_write(7'h68, 6, 2, 2, av);
      model_wr(6, 2, 2);
      chk("R7", "acks over read-only byte", av[4:0], 5'h1F);
      chk_regs("R7");
      do_read(7'h68, 6, 2, c);
      chk("R7", "read of id byte", rbuf[0], 8'h01);
      chk("R7", "byte after id byte", rbuf[1], 8'h77);
   endtask

   task automatic t_range();
      logic [31:0] av;
      logic [7:0] c;
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
      do_write(7'h68, 20, 4, 4, av);
      model_wr(20, 4, 4);
      chk_regs("R9");
      do_read(7'h68, 20, 4, c);
      chk("R9", "reg20", rbuf[0], 8'h11);
      chk("R9", "reg21", rbuf[1], 8'h22);
      chk("R9", "index 22 reads zero", rbuf[2], 8'h00);
      chk("R9", "index 23 reads zero", rbuf[3], 8'h00);
      wbuf[0] = 8'h5A;
      do_write(7'h68, 30, 1, 1, av);
      chk_regs("R9");
   endtask

   task automatic t_nack();
      logic ak;
      logic [7:0] c, d;
      bus_start();
      send_byte({7'h68, 1'b0}, ak);
      send_byte(8'h00, ak);
      bus_start();
      send_byte({7'h68, 1'b1}, ak);
      recv_byte(1'b0, c);
      chk("R10", "count byte before NACK", c, exp_r[8]);
      recv_byte(1'b0, d);
      chk("R10", "bus idle after host NACK", d, 8'hFF);
      bus_stop();
   endtask

   task automatic t_abort();
      logic [31:0] av;
      logic ak, ak2;
      // repeated start in the middle of a write
      bus_start();
      send_byte({7'h68, 1'b0}, ak);
      send_byte(8'd5, ak);
      bus_start();
      send_byte({7'h68, 1'b0}, ak);
      send_byte(8'd7, ak);
      send_byte(8'd1, ak);
      send_byte(8'h99, ak);
      bus_stop();
      exp_r[7] = 8'h99;
      chk_regs("R11");
      // restart during count phase: next byte is treated as an address
      bus_start();
      send_byte({7'h68, 1'b0}, ak);
      send_byte(8'd2, ak);
      send_byte(8'd2, ak);
      bus_start();
      send_byte(8'h55, ak2);
      bus_stop();
      chk("R11", "byte after restart seen as address", ak2, 1'b0);
      chk_regs("R11");
      // stop after the index, then a normal write
      bus_start();
      send_byte({7'h68, 1'b0}, ak);
      send_byte(8'd9, ak);
      bus_stop();
      wbuf[0] = 8'h3E;
      do_write(7'h68, 9, 1, 1, av);
      model_wr(9, 1, 1);
      chk("R11", "write after aborted transfer", av[3:0], 4'hF);
      chk_regs("R11");
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) begin
         case (i)
            0: exp_r[i] = 8'h02;
            1: exp_r[i] = 8'hFF;
            2: exp_r[i] = 8'h3F;
            5: exp_r[i] = 8'h3C;
            6: exp_r[i] = 8'h01;
            7: exp_r[i] = 8'h22;
            8: exp_r[i] = 8'h09;
            default: exp_r[i] = 8'h00;
         endcase
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_address();
      t_block_write();
      t_overcount();
      t_read();
      t_readonly();
      t_range();
      t_nack();
      t_abort();
      chk("R12", "SDA drive changes while SCL high", r12_viol, 0);
      summary();
      $finish;
   end

endmodule